// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 single-cycle hardware event pulses into sticky cause bits and combines them into one interrupt line. Software reaches it through a plain register port with an address, write and read strobes, write data and combinational read data. It can read the raw causes or only the unmasked causes, inject causes itself, and change the mask with a direct write or with atomic set and clear aliases.

For each bit, software picks how it is acknowledged. With a 0 in the control register, a bit clears when software writes a 1 to it. With a 1 in the control register, a bit clears when software reads it. The interrupt output is the registered OR of all causes that are not masked.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, the cause bits and control bits are all 0, every mask bit is 1, and `irq_out` is 0.
- R2: An `evt_in` pulse on bit i sets cause bit i at the next clock edge. Address 1 reads the cause vector.
- R3: Address 0 is the control register and can be read and written. While control bit i is 0, writing a 1 to bit i at address 1 clears cause bit i. Writing a 0 leaves that bit as it is.
- R4: While control bit i is 1, a read at address 1 clears cause bit i only if that bit was 1 in the returned value. Writes to address 1 leave such a bit unchanged.
- R5: Address 2 reads the cause vector ANDed with the inverted mask. Reads and writes at address 2 clear bits by the same per-bit rule as address 1, but only bits whose mask is 0.
- R6: Writing a 1 to bit i at address 3 sets cause bit i. Writing a 0 has no effect.
- R7: Address 4 is the mask, which can be read and written directly. A 1 blocks that source.
- R8: Writing a 1 at address 5 sets that mask bit. Writing a 1 at address 6 clears that mask bit. Zero bits leave the mask unchanged.
- R9: `irq_out` equals the OR of (cause AND NOT mask) as it stood one clock edge earlier.
- R10: When a set (from an event or from address 3) and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: Reads at addresses 3, 5, 6 and 7 return zero and change no state. Writes to address 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NSRC | Write data |
| reg_rd | input | 1 | Read strobe (triggers clear-on-read) |
| reg_rdata | output | NSRC | Combinational read data for reg_addr |
| evt_in | input | NSRC | One-cycle event pulses, one per source |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the bank with NSRC at its default of 32. At that width, the top bit and the bottom bit are both exercised, which reaches the edges of every per-bit path. The vector table walks all seven registers and follows how a mask change shows up on `irq_out` one cycle later. Directed cases cover collisions between a set and a clear, a clear-on-read racing a new event, and clears through the masked view that leave masked bits alone. They also cover reads of the write-only addresses and a reset in the middle of a run.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [NSRC-1:0] reg_wdata,
  input  logic            reg_rd,
  output logic [NSRC-1:0] reg_rdata,
  input  logic [NSRC-1:0] evt_in,
  output logic            irq_out
);
  localparam logic [2:0] A_CTL = 3'd0, A_CAUSE = 3'd1, A_MASKED = 3'd2, A_SET = 3'd3,
                         A_MASK = 3'd4, A_MSET = 3'd5, A_MCLR = 3'd6;

  logic [NSRC-1:0] ctl_q, cause_q, mask_q, masked;
  logic [NSRC-1:0] clr_wr, clr_rd, set_v, cause_d, mask_d;
  logic            irq_q;

  assign masked = cause_q & ~mask_q;

  assign clr_wr = ((reg_wr && reg_addr == A_CAUSE)  ? (reg_wdata & ~ctl_q)           : '0)
                | ((reg_wr && reg_addr == A_MASKED) ? (reg_wdata & ~ctl_q & ~mask_q) : '0);
  assign clr_rd = ((reg_rd && reg_addr == A_CAUSE)  ? (cause_q & ctl_q) : '0)
                | ((reg_rd && reg_addr == A_MASKED) ? (masked & ctl_q)  : '0);
  assign set_v  = evt_in | ((reg_wr && reg_addr == A_SET) ? reg_wdata : '0);
  assign cause_d = (cause_q & ~(clr_wr | clr_rd)) | set_v;

  always_comb begin
    mask_d = mask_q;
    if (reg_wr) begin
      case (reg_addr)
        A_MASK:  mask_d = reg_wdata;
        A_MSET:  mask_d = mask_q | reg_wdata;
        A_MCLR:  mask_d = mask_q & ~reg_wdata;
        default: mask_d = mask_q;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:    reg_rdata = ctl_q;
      A_CAUSE:  reg_rdata = cause_q;
      A_MASKED: reg_rdata = masked;
      A_MASK:   reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cause_q <= '0;
      mask_q  <= '1;
      irq_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTL) ctl_q <= reg_wdata;
      cause_q <= cause_d;
      mask_q  <= mask_d;
      irq_q   <= |masked;
    end
  end

  assign irq_out = irq_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((cause_q & $past(set_v)) == $past(set_v)));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == |($past(cause_q) & ~$past(mask_q))));

  assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SET || reg_addr == A_MSET || reg_addr == A_MCLR || reg_addr == 3'd7)
      |-> (reg_rdata == '0));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr && reg_addr == A_MSET))
      |-> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  assert_cor_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_rd && !reg_wr && reg_addr == A_CAUSE))
      |-> ((cause_q & $past(ctl_q & cause_q & ~evt_in)) == '0));
endmodule

// File: tb/tb_irq_cause_bank.sv
module tb_irq_cause_bank;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, evt_in = '0, reg_rdata;
  logic        irq_out;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] got_rd;
  logic        got_irq;
  bit          done = 0;

  always #5 clk = ~clk;

  irq_cause_bank #(.NSRC(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_out(irq_out));

  typedef struct packed {
    logic        wr, rd;
    logic [2:0]  addr;
    logic [31:0] wdata, evt, exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam vec_t TBL [21] = '{
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0},               // R1 cause reset
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFFFFFF,1'b0},        // R1 mask reset
    '{1'b0,1'b1,3'd2,32'h0,32'h5,32'h0,1'b0},               // R2 events
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h5,1'b0},               // R2
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h0,1'b0},               // R5 all masked
    '{1'b1,1'b0,3'd6,32'h1,32'h0,32'h0,1'b0},               // R8 mask clear
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h1,1'b0},               // R5
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h1,1'b1},               // R9
    '{1'b1,1'b0,3'd1,32'h1,32'h0,32'h5,1'b1},               // R3 w1c
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h4,1'b1},               // R3
    '{1'b1,1'b0,3'd0,32'h4,32'h0,32'h0,1'b0},               // R3 ctl write
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h4,1'b0},               // R4 cor
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0},               // R4
    '{1'b1,1'b0,3'd3,32'h80000000,32'h0,32'h0,1'b0},        // R6 set
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h80000000,1'b0},        // R6
    '{1'b1,1'b0,3'd4,32'h7FFFFFFF,32'h0,32'hFFFFFFFE,1'b0}, // R7 direct mask
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h80000000,1'b0},        // R5
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'h7FFFFFFF,1'b1},        // R7
    '{1'b1,1'b0,3'd5,32'h80000000,32'h0,32'h0,1'b1},        // R8 mask set
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFFFFFF,1'b1},        // R8
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h0,1'b0}                // R9
  };

  task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [31:0] wd, input logic [31:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; evt_in = ev;
    #1;
    got_rd = reg_rdata;
    got_irq = irq_out;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    for (int i = 0; i < 21; i++) begin
      cyc(TBL[i].wr, TBL[i].rd, TBL[i].addr, TBL[i].wdata, TBL[i].evt);
      chk($sformatf("table row %0d rdata", i), got_rd, TBL[i].exp_rd);
      chk($sformatf("R9 table row %0d irq", i), {31'b0, got_irq}, {31'b0, TBL[i].exp_irq});
    end
    // R10: w1c on bit 31 collides with an event
    cyc(1, 0, 3'd0, 32'h0, 32'h0);                 // ctl = 0
    cyc(1, 0, 3'd1, 32'h80000000, 32'h80000000);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R10 set beats w1c", got_rd, 32'h80000000);
    cyc(1, 0, 3'd1, 32'h80000000, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R3 w1c bit31", got_rd, 32'h0);
    // R4/R10: event during a clear-on-read of a bit that read back 0
    cyc(1, 0, 3'd0, 32'h4, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h4);
    chk("R4 read before event", got_rd, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R4 event kept", got_rd, 32'h4);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R4 cleared by read", got_rd, 32'h0);
    // R5: masked read clears only unmasked cor bits
    cyc(1, 0, 3'd0, 32'h3, 32'h3);
    cyc(1, 0, 3'd6, 32'h1, 32'h0);
    cyc(0, 1, 3'd2, 32'h0, 32'h0);
    chk("R5 masked read", got_rd, 32'h1);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R5 masked bit kept", got_rd, 32'h2);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R4 cause read clears", got_rd, 32'h0);
    // R5: masked w1c write touches only unmasked bits
    cyc(1, 0, 3'd0, 32'h0, 32'h30);
    cyc(1, 0, 3'd6, 32'h10, 32'h0);
    cyc(1, 0, 3'd2, 32'h30, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R5 masked write", got_rd, 32'h20);
    // R11: write-only reads give zero and no side effect
    cyc(0, 1, 3'd3, 32'h0, 32'h0);
    chk("R11 set reads 0", got_rd, 32'h0);
    cyc(0, 1, 3'd5, 32'h0, 32'h0);
    chk("R11 mset reads 0", got_rd, 32'h0);
    cyc(0, 1, 3'd6, 32'h0, 32'h0);
    chk("R11 mclr reads 0", got_rd, 32'h0);
    cyc(1, 1, 3'd7, 32'hFFFFFFFF, 32'h0);
    chk("R11 addr7 reads 0", got_rd, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R11 cause unchanged", got_rd, 32'h20);
    cyc(0, 1, 3'd4, 32'h0, 32'h0);
    chk("R11 mask unchanged", got_rd, 32'hFFFFFFEE);
    cyc(0, 1, 3'd0, 32'h0, 32'h0);
    chk("R11 ctl unchanged", got_rd, 32'h0);
    // R6: zero write to set register does nothing
    cyc(1, 0, 3'd3, 32'h0, 32'h0);
    cyc(0, 1, 3'd1, 32'h0, 32'h0);
    chk("R6 zero set", got_rd, 32'h20);
    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0; reg_wr = 0; reg_rd = 0;
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 3'd1, 32'h0, 32'h0);
    chk("R1 cause after reset", got_rd, 32'h0);
    chk("R1 irq after reset", {31'b0, got_irq}, 32'h0);
    cyc(0, 0, 3'd4, 32'h0, 32'h0);
    chk("R1 mask after reset", got_rd, 32'hFFFFFFFF);
    cyc(0, 0, 3'd0, 32'h0, 32'h0);
    chk("R1 ctl after reset", got_rd, 32'h0);
    summary();
  end
endmodule